// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide static RAM in which every word has a nonvolatile shadow twin. It also holds the control logic that moves whole arrays between the two. In normal operation the block behaves like a plain SRAM. The SRAM-style port has an address, data in, data out, an active-low chip enable, an active-low write enable and an active-low output enable. That port is sampled on the rising clock edge of a synchronous core. Reads and writes touch only the working array.

A bulk transfer can be started in four ways: power loss, power return, a pulse on the hardware store pin, or a watched sequence of six read addresses. A STORE copies the whole working array into the shadow. A RECALL first zeroes the working array and then loads it from the shadow. The transfer engine walks one word per clock. A busy output covers the whole run, and the SRAM port is shut off while it is high.

The address port is `ADDR_W` bits wide (15 by default, a 32768-word space). The arrays hold 2^`ARR_AW` words, and an address selects the word given by its low `ARR_AW` bits, so a small array can be used in simulation.

Top module: `nvshadow_sram`

## Requirements
- R1: In SRAM mode, with `ce_n`=0 and `we_n`=0 at a rising edge, `din` is written to the word at `addr` modulo 2^`ARR_AW`. With `ce_n`=0 and `we_n`=1, that word appears on `dout` from the following cycle while `oe_n`=0. `dout` reads 0 while `oe_n`=1.
- R2: After reset, `busy` is 0 and `dout` is 0.
- R3: A falling edge on `pwr_good` while no STORE is running starts a STORE. `busy` stays high for exactly 2^`ARR_AW` cycles, and the shadow then equals the working array.
- R4: A rising edge on `pwr_good` while idle starts a RECALL. `busy` stays high for exactly 2×2^`ARR_AW` cycles, after which the working array equals the shadow. A RECALL never changes the shadow, so repeated recalls give the same contents.
- R5: A high-to-low transition of `hw_store_n` while idle starts a STORE.
- R6: Six consecutive reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 start a STORE on the edge of the sixth read.
- R7: Six consecutive reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0C63 start a RECALL on the edge of the sixth read.
- R8: A write, or a read of any address other than the expected next one, cancels a partly entered sequence. Detection restarts at the first step, and a mismatching read of 0x0E38 counts as that first step. Cycles with `ce_n`=1 do not break a sequence.
- R9: While `busy` is 1, writes are dropped, reads neither update the held read data nor break anything, and `dout` is 0.
- R10: A RECALL first zeroes word 0 upward, one word per cycle, and then loads from the shadow. A falling `pwr_good` during either phase abandons the RECALL after that cycle's word and starts a STORE at once.
- R11: A hardware or software STORE request that arrives while a transfer is running is ignored, and the running transfer keeps its length.
- R12: When `pwr_good` falls in the same cycle as the sixth read of the RECALL sequence, only the STORE runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when disabled or busy |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hw_store_n | input | 1 | Hardware store request, falling edge acts |
| pwr_good | input | 1 | Supply status, fall = power loss, rise = power return |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
The critical collision is a power loss that lands in the same cycle as the last read of the RECALL sequence, where the store must win. The bench provokes it by lowering `pwr_good` on the same edge as that sixth read. It then judges the outcome by the busy length, which must be one array length and not two, and by a later recall that must return the data written just before the race. A second overlap, power loss in the middle of a recall's clearing phase, is judged by which words come back zero after the resulting store and a fresh recall.

// File: rtl/nv_pkg.sv
package nv_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_STORE = 2'd1,
    XF_CLEAR = 2'd2,
    XF_LOAD  = 2'd3
  } xfer_state_e;

  localparam int unsigned SEQ_LEN = 6;

  // Address expected at a given step of a software sequence
  function automatic logic [15:0] seq_key(input logic [2:0] step, input logic recall);
    logic [15:0] k;
    case (step)
      3'd0:    k = 16'h0E38;
      3'd1:    k = 16'h31C7;
      3'd2:    k = 16'h03E0;
      3'd3:    k = 16'h3C1F;
      3'd4:    k = 16'h303F;
      default: k = recall ? 16'h0C63 : 16'h0FC0;
    endcase
    return k;
  endfunction

  // Cycles a transfer holds busy for a given array depth
  function automatic int unsigned xfer_cycles(input int unsigned depth, input logic recall);
    return recall ? 2 * depth : depth;
  endfunction

endpackage

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
  import nv_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              fire_store,
  output logic              fire_recall
);

  localparam logic [2:0] STEP_LAST = 3'(SEQ_LEN - 1);

  logic [2:0]  step_q, step_d;
  logic [15:0] key_cur, key_first, key_st, key_rc;
  logic        hit_cur, hit_first, hit_st, hit_rc, at_last;

  assign key_cur   = seq_key(step_q, 1'b0);
  assign key_first = seq_key(3'd0, 1'b0);
  assign key_st    = seq_key(STEP_LAST, 1'b0);
  assign key_rc    = seq_key(STEP_LAST, 1'b1);

  assign hit_cur   = (addr == key_cur[ADDR_W-1:0]);
  assign hit_first = (addr == key_first[ADDR_W-1:0]);
  assign hit_st    = (addr == key_st[ADDR_W-1:0]);
  assign hit_rc    = (addr == key_rc[ADDR_W-1:0]);
  assign at_last   = (step_q == STEP_LAST);

  assign fire_store  = acc_rd && at_last && hit_st;
  assign fire_recall = acc_rd && at_last && hit_rc;

  always_comb begin
    step_d = step_q;
    if (!enable) begin
      step_d = 3'd0;
    end else if (acc_wr) begin
      step_d = 3'd0;
    end else if (acc_rd) begin
      if (!at_last && hit_cur)
        step_d = step_q + 3'd1;
      else if (at_last && (hit_st || hit_rc))
        step_d = 3'd0;
      else
        step_d = hit_first ? 3'd1 : 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 3'd0;
    else        step_q <= step_d;
  end

  // R8
  seq_write_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && acc_wr) |=> (step_q == 3'd0));

  // R6
  seq_fire_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_store || fire_recall) |=> (step_q == 3'd0));

endmodule

// File: rtl/nv_xfer_engine.sv
module nv_xfer_engine
  import nv_pkg::*;
#(
  parameter int ARR_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_loss,
  input  logic              user_store,
  input  logic              recall_req,
  output xfer_state_e       state_o,
  output logic [ARR_AW-1:0] idx_o,
  output logic              busy_o
);

  localparam int unsigned     DEPTH      = 1 << ARR_AW;
  localparam logic [ARR_AW-1:0] IDX_LAST = '1;
  localparam int              RUN_W      = ARR_AW + 2;
  localparam int unsigned     ST_CYC     = xfer_cycles(DEPTH, 1'b0);
  localparam int unsigned     RC_CYC     = xfer_cycles(DEPTH, 1'b1);
  localparam logic [RUN_W-1:0] ST_LAST_RUN = RUN_W'(ST_CYC - 1);
  localparam logic [RUN_W-1:0] RC_LAST_RUN = RUN_W'(RC_CYC - 1);

  xfer_state_e       state_q, state_d;
  logic [ARR_AW-1:0] idx_q, idx_d;
  logic              idx_end;
  logic              start_w;
  logic [RUN_W-1:0]  run_q;

  assign idx_end = (idx_q == IDX_LAST);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      XF_IDLE: begin
        if (pwr_loss || user_store) begin
          state_d = XF_STORE;
          idx_d   = '0;
        end else if (recall_req) begin
          state_d = XF_CLEAR;
          idx_d   = '0;
        end
      end
      XF_STORE: begin
        if (idx_end) begin
          state_d = XF_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      XF_CLEAR: begin
        if (pwr_loss) begin
          state_d = XF_STORE;
          idx_d   = '0;
        end else if (idx_end) begin
          state_d = XF_LOAD;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      XF_LOAD: begin
        if (pwr_loss) begin
          state_d = XF_STORE;
          idx_d   = '0;
        end else if (idx_end) begin
          state_d = XF_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign busy_o  = (state_q != XF_IDLE);

  // Independent cycle count of the current run, for the length checks
  assign start_w = ((state_d == XF_STORE) && (state_q != XF_STORE)) ||
                   ((state_d == XF_CLEAR) && (state_q == XF_IDLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (start_w) run_q <= '0;
    else if (busy_o)  run_q <= run_q + 1'b1;
  end

  // R3
  store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_STORE && state_d == XF_IDLE) |-> (run_q == ST_LAST_RUN));

  // R4
  recall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_LOAD && state_d == XF_IDLE) |-> (run_q == RC_LAST_RUN));

  // R10
  recall_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_loss && (state_q == XF_CLEAR || state_q == XF_LOAD))
      |=> (state_q == XF_STORE && idx_q == '0));

  // R11
  store_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_store && state_q == XF_STORE && !idx_end)
      |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/nv_cell_arrays.sv
module nv_cell_arrays
  import nv_pkg::*;
#(
  parameter int ARR_AW = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_state_e       xfer_st,
  input  logic [ARR_AW-1:0] xfer_idx,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic [ARR_AW-1:0] port_idx,
  input  logic [DATA_W-1:0] port_din,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] work_mem   [DEPTH];
  logic [DATA_W-1:0] shadow_mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // One word moves per cycle; the port writes only while idle
  always_ff @(posedge clk) begin
    unique case (xfer_st)
      XF_STORE: shadow_mem[xfer_idx] <= work_mem[xfer_idx];
      XF_CLEAR: work_mem[xfer_idx]   <= '0;
      XF_LOAD:  work_mem[xfer_idx]   <= shadow_mem[xfer_idx];
      XF_IDLE:  if (port_wr) work_mem[port_idx] <= port_din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (port_rd) rd_q <= work_mem[port_idx];
  end

  assign rd_data = rd_q;

  // R9
  rd_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_st != XF_IDLE) |=> $stable(rd_q));

endmodule

// File: rtl/nvshadow_sram.sv
module nvshadow_sram
  import nv_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              hw_store_n,
  input  logic              pwr_good,
  output logic              busy
);

  logic              pg_q, hs_q;
  logic              pg_fell_w, pg_rose_w, hw_fell_w;
  logic              acc_rd_w, acc_wr_w;
  logic              sw_store_w, sw_recall_w;
  logic              user_store_w, recall_req_w;
  xfer_state_e       xfer_st;
  logic [ARR_AW-1:0] xfer_idx;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      hs_q <= 1'b1;
    end else begin
      pg_q <= pwr_good;
      hs_q <= hw_store_n;
    end
  end

  assign pg_fell_w = pg_q & ~pwr_good;
  assign pg_rose_w = ~pg_q & pwr_good;
  assign hw_fell_w = hs_q & ~hw_store_n;

  assign acc_rd_w = ~ce_n & ~busy & we_n;
  assign acc_wr_w = ~ce_n & ~busy & ~we_n;

  nv_seq_detect #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (~busy),
    .acc_rd     (acc_rd_w),
    .acc_wr     (acc_wr_w),
    .addr       (addr),
    .fire_store (sw_store_w),
    .fire_recall(sw_recall_w)
  );

  assign user_store_w = hw_fell_w | sw_store_w;
  assign recall_req_w = pg_rose_w | sw_recall_w;

  nv_xfer_engine #(.ARR_AW(ARR_AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_loss  (pg_fell_w),
    .user_store(user_store_w),
    .recall_req(recall_req_w),
    .state_o   (xfer_st),
    .idx_o     (xfer_idx),
    .busy_o    (busy)
  );

  nv_cell_arrays #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer_st (xfer_st),
    .xfer_idx(xfer_idx),
    .port_wr (acc_wr_w),
    .port_rd (acc_rd_w),
    .port_idx(addr[ARR_AW-1:0]),
    .port_din(din),
    .rd_data (rd_data)
  );

  assign dout = (!oe_n && !busy) ? rd_data : '0;

  // R3
  pwr_loss_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_fell_w && xfer_st != XF_STORE) |=> (xfer_st == XF_STORE));

  // R5
  hw_pin_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fell_w && xfer_st == XF_IDLE) |=> (xfer_st == XF_STORE));

  // R12
  race_store_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_fell_w && sw_recall_w) |=> (xfer_st == XF_STORE));

  // R7
  sw_recall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_recall_w && !pg_fell_w) |=> (xfer_st == XF_CLEAR));

endmodule

// File: tb/nvshadow_sram_tb.sv
`timescale 1ns/1ps
module nvshadow_sram_tb;

  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int ARR_AW = 6;
  localparam int N      = 1 << ARR_AW;
  localparam int KCLR   = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic              hw_store_n = 1'b1, pwr_good = 1'b0;
  logic              busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nvshadow_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .hw_store_n(hw_store_n), .pwr_good(pwr_good), .busy(busy)
  );

  // Vector: {is_read, address, data-or-expected}
  localparam int NVEC = 10;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 15'h0000, 8'hA5}, {1'b0, 15'h0001, 8'h3C}, {1'b0, 15'h003F, 8'h7E},
    {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h003F, 8'h7E}, {1'b0, 15'h0040, 8'h99},
    {1'b1, 15'h0000, 8'h99}, {1'b1, 15'h0001, 8'h3C}, {1'b0, 15'h7FFF, 8'h42},
    {1'b1, 15'h003F, 8'h42}
  };

  localparam logic [14:0] K0 = 15'h0E38, K1 = 15'h31C7, K2 = 15'h03E0,
                          K3 = 15'h3C1F, K4 = 15'h303F, KST = 15'h0FC0, KRC = 15'h0C63;

  function automatic logic [7:0] pat(input int kind, input int i);
    case (kind)
      0: return 8'(i * 7 + 3);
      1: return ~8'(i * 7 + 3);
      2: return 8'(i) ^ 8'h5A;
      3: return 8'(i * 5 + 17);
      4: return 8'(i) | 8'h80;
      5: return (i <= KCLR) ? 8'h00 : (8'(i) | 8'h80);
      default: return 8'(i * 3 + 1);
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(posedge clk);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_read(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); ce_n = 1'b1; d = dout;
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < N; i++) do_write(15'(i), pat(kind, i));
  endtask

  task automatic verify(input int kind, input string tag);
    logic [7:0] d;
    for (int i = 0; i < N; i++) begin
      do_read(15'(i), d);
      chk(tag, d, pat(kind, i));
    end
  endtask

  // Counts negedges with busy high, starting with the present instant
  task automatic measure(input int win, output int cnt);
    cnt = busy ? 1 : 0;
    repeat (win - 1) begin
      @(negedge clk);
      if (busy) cnt++;
    end
  endtask

  task automatic sw_seq(input logic recall);
    logic [7:0] d;
    do_read(K0, d); do_read(K1, d); do_read(K2, d);
    do_read(K3, d); do_read(K4, d); do_read(recall ? KRC : KST, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    logic [7:0] d;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 busy after reset", busy, 0);
    chk("R2 dout after reset", dout, 0);

    // R1 vector table
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][23]) begin
        do_read(VEC[v][22:8], d);
        chk("R1 vector read", d, VEC[v][7:0]);
      end else begin
        do_write(VEC[v][22:8], VEC[v][7:0]);
      end
    end
    oe_n = 1'b1;
    do_read(15'h0001, d);
    chk("R1 oe_n high gives 0", d, 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R1 oe_n low restores", dout, 8'h3C);

    // R5 pin store with intrusions (R9, R11)
    fill(0);
    @(negedge clk); hw_store_n = 1'b0;
    @(posedge clk);
    cnt = 0;
    for (int c = 0; c < 3 * N; c++) begin
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; hw_store_n = 1'b1;
      if (c == 2) begin
        ce_n = 1'b0; we_n = 1'b0; addr = 15'd5; din = 8'hAA; hw_store_n = 1'b0;
      end
      if (c == 3) begin ce_n = 1'b0; addr = 15'd9; end
      if (c == 5) chk("R9 dout zero while busy", dout, 0);
      if (busy) cnt++;
    end
    chk("R5 R11 pin store length", cnt, N);
    do_read(15'd5, d);
    chk("R9 write during busy dropped", d, pat(0, 5));

    // R4 power-up recall
    fill(1);
    @(negedge clk); pwr_good = 1'b1;
    measure(3 * N, cnt);
    chk("R4 recall length", cnt, 2 * N);
    verify(0, "R4 recall data");

    // R3 power-loss store
    fill(2);
    @(negedge clk); pwr_good = 1'b0;
    measure(3 * N, cnt);
    chk("R3 store length", cnt, N);
    @(negedge clk); pwr_good = 1'b1;
    measure(3 * N, cnt);
    verify(2, "R3 stored data recalled");

    // R7 software recall, shadow unchanged by earlier recall (R4)
    for (int i = 0; i < 4; i++) do_write(15'(i), 8'h00);
    sw_seq(1'b1);
    measure(3 * N, cnt);
    chk("R7 sw recall length", cnt, 2 * N);
    verify(2, "R4 R7 repeated recall data");

    // R6 software store
    fill(3);
    sw_seq(1'b0);
    measure(3 * N, cnt);
    chk("R6 sw store length", cnt, N);
    fill(1);
    sw_seq(1'b1);
    measure(3 * N, cnt);
    verify(3, "R6 sw stored data");

    // R8 aborted sequences
    do_write(15'd0, 8'h11);
    do_read(K0, d); do_read(K1, d); do_read(K2, d);
    do_write(15'd1, 8'h22);
    do_read(K3, d); do_read(K4, d); do_read(KST, d);
    measure(10, cnt);
    chk("R8 write breaks store sequence", cnt, 0);
    do_read(K0, d); do_read(K1, d); do_read(15'h0001, d);
    do_read(K2, d); do_read(K3, d); do_read(K4, d); do_read(KST, d);
    measure(10, cnt);
    chk("R8 stray read breaks sequence", cnt, 0);
    do_read(15'd0, d);
    chk("R8 word intact after abort", d, 8'h11);
    do_read(K0, d); do_read(15'h0002, d);
    do_read(K0, d); do_read(K1, d); do_read(K2, d);
    do_read(K3, d); do_read(K4, d); do_read(KRC, d);
    measure(3 * N, cnt);
    chk("R8 restart at first step", cnt, 2 * N);
    do_read(15'd0, d);
    chk("R8 no store happened", d, pat(3, 0));

    // R10 power loss during clearing phase
    fill(4);
    sw_seq(1'b1);
    chk("R10 recall running", busy, 1);
    repeat (KCLR) @(posedge clk);
    @(negedge clk); pwr_good = 1'b0;
    @(posedge clk);
    @(negedge clk);
    measure(3 * N, cnt);
    chk("R10 store after abandoned recall", cnt, N);
    @(negedge clk); pwr_good = 1'b1;
    measure(3 * N, cnt);
    verify(5, "R10 clear order");

    // R12 power loss with the sixth recall read
    fill(6);
    do_read(K0, d); do_read(K1, d); do_read(K2, d); do_read(K3, d); do_read(K4, d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = KRC; pwr_good = 1'b0;
    @(posedge clk);
    @(negedge clk); ce_n = 1'b1;
    measure(3 * N, cnt);
    chk("R12 only store runs", cnt, N);
    @(negedge clk); pwr_good = 1'b1;
    measure(3 * N, cnt);
    verify(6, "R12 raced store data");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule